// File: doc/BRIEF.md
# Self-Timed Burst Controller with Local Clock

This block is a cycle-based model of a two-state burst-mode controller that makes its own local clock. Three request inputs (a, b, c) arrive in bursts. Three responses (x, y, z) come from combinational logic through a phase-1 register stage. A single state bit is 0 in the resting state and 1 in the excited state. A transition is taken only when the whole burst that leaves the present state has been seen. The excited state is entered when a, b and c are all high, and it is left when all three are low again.

When the phase-1 stage holds a next state that differs from the current one, a settle counter runs for `SETTLE_CYC` system cycles. The local clock then rises for two cycles. During those cycles phase-1 is closed and phase-2 opens, so the new state is loaded and fed back. The clock drops once the returned state matches. Bursts that cause no state change never fire the clock. An input change that arrives while this sequence is running is ignored and raises a sticky protocol-error flag. The local clock and both phase enables are brought out for debug.

Top module: `burst_lclk_fsm`

## Requirements
- R1: After reset x, y, z, the local clock, the phase-2 enable and the error flag are 0, the phase-1 enable is 1, and the state bit is 0.
- R2: While the state bit is 0, z settles to a AND b, and x and y settle to a AND b AND c.
- R3: While the state bit is 1, x, y and z all settle to a OR b OR c, so a partial withdrawal of the inputs leaves all three responses at 1.
- R4: The local clock fires only when the state changes. State 0 goes to 1 only when a, b and c are all 1. State 1 goes to 0 only when all three are 0. When the clock rises, x, y and z already show the complete burst: 111 when entering state 1, 000 when leaving it.
- R5: The local clock goes high at the (SETTLE_CYC+2)-th rising system clock edge, counting the first edge that samples the completing input change as the 1st. SETTLE_CYC must be at least 1.
- R6: Each firing keeps the local clock high for exactly 2 cycles. While it is high, the phase-2 enable is 1, the phase-1 enable is 0 and x, y, z do not change.
- R7: An input change that arrives from the cycle a transition is detected until phase-1 reopens is ignored by the outputs and sets the error flag, which stays 1 until reset. Input changes while the controller is idle never set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_i | input | 1 | Request input a |
| b_i | input | 1 | Request input b |
| c_i | input | 1 | Request input c |
| x_o | output | 1 | Response x from phase-1 stage |
| y_o | output | 1 | Response y from phase-1 stage |
| z_o | output | 1 | Response z from phase-1 stage |
| lclk_o | output | 1 | Debug copy of the local clock |
| p1_en_o | output | 1 | Debug: phase-1 stage open |
| p2_en_o | output | 1 | Debug: phase-2 stage open |
| err_o | output | 1 | Sticky protocol-error flag |

## Verification
The properties assume the environment honours the fundamental-mode rule between bursts, except in the one directed case that breaks it on purpose to exercise the error flag. That rule is what makes the outputs at a clock rise the complete-burst values. The stimulus applies one input change per step and then holds the inputs for more cycles than the settle delay plus the two-cycle firing. Every sequence therefore ends before the next burst begins. Only the glitch test changes an input inside a running sequence, and it restores the input before phase-1 reopens.

// File: rtl/burst_lclk_pkg.sv
package burst_lclk_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_SETTLE = 2'd1,
        SEQ_FIRE   = 2'd2
    } seq_e;

    typedef struct packed {
        logic x;
        logic y;
        logic z;
    } resp_t;
endpackage

// File: rtl/burst_lclk_logic.sv
// Next-state and response logic of the two-state burst machine.
module burst_lclk_logic
    import burst_lclk_pkg::*;
(
    input  logic [2:0] abc_i,   // [2]=a [1]=b [0]=c
    input  logic       s_i,
    output resp_t      resp_o,
    output logic       s_nxt_o
);
    logic all_hi, any_hi, ab_hi;

    always_comb begin
        all_hi = &abc_i;
        any_hi = |abc_i;
        ab_hi  = abc_i[2] & abc_i[1];
        if (!s_i) begin
            resp_o.x = all_hi;
            resp_o.y = all_hi;
            resp_o.z = ab_hi;
            s_nxt_o  = all_hi;
        end else begin
            resp_o.x = any_hi;
            resp_o.y = any_hi;
            resp_o.z = any_hi;
            s_nxt_o  = any_hi;
        end
    end
endmodule

// File: rtl/burst_lclk_stage.sv
// Input capture, phase-1 register stage and protocol-error flag.
module burst_lclk_stage
    import burst_lclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] abc_i,
    input  logic       accept_i,   // idle and no transition pending
    input  logic       p1_en_i,
    input  resp_t      resp_i,
    input  logic       s_nxt_i,
    output logic [2:0] abc_q_o,
    output resp_t      resp_q_o,
    output logic       s_nxt_q_o,
    output logic       err_o
);
    typedef struct packed {
        logic [2:0] abc;
        resp_t      resp;
        logic       s_nxt;
        logic       err;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (accept_i) begin
            st_d.abc = abc_i;
        end else if (abc_i != st_q.abc) begin
            st_d.err = 1'b1;
        end
        if (p1_en_i) begin
            st_d.resp  = resp_i;
            st_d.s_nxt = s_nxt_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign abc_q_o   = st_q.abc;
    assign resp_q_o  = st_q.resp;
    assign s_nxt_q_o = st_q.s_nxt;
    assign err_o     = st_q.err;
endmodule

// File: rtl/burst_lclk_seq.sv
// Local clock sequencer with settle counter and phase-2 state register.
module burst_lclk_seq
    import burst_lclk_pkg::*;
#(
    parameter int SETTLE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chg_i,      // combinational next state differs from state
    input  logic s_nxt_q_i,  // next state held in phase-1
    output logic s_q_o,
    output logic idle_o,
    output logic p1_en_o,
    output logic p2_en_o,
    output logic lclk_o
);
    localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

    typedef struct packed {
        seq_e             st;
        logic [CNT_W-1:0] cnt;
        logic             s;
    } seq_t;

    seq_t sq_d, sq_q;

    always_comb begin
        sq_d = sq_q;
        case (sq_q.st)
            SEQ_IDLE: begin
                if (chg_i) begin
                    sq_d.st  = SEQ_SETTLE;
                    sq_d.cnt = '0;
                end
            end
            SEQ_SETTLE: begin
                if (sq_q.cnt == CNT_LAST) begin
                    sq_d.st = SEQ_FIRE;
                end else begin
                    sq_d.cnt = sq_q.cnt + 1'b1;
                end
            end
            SEQ_FIRE: begin
                sq_d.s = s_nxt_q_i;
                if (sq_q.s == s_nxt_q_i) begin
                    sq_d.st = SEQ_IDLE;
                end
            end
            default: sq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q <= '{st: SEQ_IDLE, cnt: '0, s: 1'b0};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign s_q_o   = sq_q.s;
    assign idle_o  = (sq_q.st == SEQ_IDLE);
    assign lclk_o  = (sq_q.st == SEQ_FIRE);
    assign p2_en_o = (sq_q.st == SEQ_FIRE);
    assign p1_en_o = (sq_q.st != SEQ_FIRE);
endmodule

// File: rtl/burst_lclk_fsm.sv
module burst_lclk_fsm
    import burst_lclk_pkg::*;
#(
    parameter int SETTLE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic x_o,
    output logic y_o,
    output logic z_o,
    output logic lclk_o,
    output logic p1_en_o,
    output logic p2_en_o,
    output logic err_o
);
    logic [2:0] abc_q;
    resp_t      resp_c, resp_q;
    logic       s_nxt_c, s_nxt_q, s_q;
    logic       idle, chg, accept, p1_en;

    burst_lclk_logic u_logic (
        .abc_i   (abc_q),
        .s_i     (s_q),
        .resp_o  (resp_c),
        .s_nxt_o (s_nxt_c)
    );

    assign chg    = (s_nxt_c != s_q);
    assign accept = idle & ~chg;

    burst_lclk_stage u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .abc_i     ({a_i, b_i, c_i}),
        .accept_i  (accept),
        .p1_en_i   (p1_en),
        .resp_i    (resp_c),
        .s_nxt_i   (s_nxt_c),
        .abc_q_o   (abc_q),
        .resp_q_o  (resp_q),
        .s_nxt_q_o (s_nxt_q),
        .err_o     (err_o)
    );

    burst_lclk_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .chg_i     (chg),
        .s_nxt_q_i (s_nxt_q),
        .s_q_o     (s_q),
        .idle_o    (idle),
        .p1_en_o   (p1_en),
        .p2_en_o   (p2_en_o),
        .lclk_o    (lclk_o)
    );

    assign p1_en_o = p1_en;
    assign x_o     = resp_q.x;
    assign y_o     = resp_q.y;
    assign z_o     = resp_q.z;
endmodule

// File: rtl/burst_lclk_chk.sv
module burst_lclk_chk (
    input logic clk,
    input logic rst_n,
    input logic x_o,
    input logic y_o,
    input logic z_o,
    input logic lclk_o,
    input logic p1_en_o,
    input logic p2_en_o,
    input logic err_o
);
    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(p1_en_o && p2_en_o)); // R6
    AST_OUT_FROZEN_P2: assert property (@(posedge clk) disable iff (!rst_n) p2_en_o |=> $stable({x_o, y_o, z_o})); // R6
    AST_LCLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $rose(lclk_o) |=> lclk_o); // R6
    AST_LCLK_DROP: assert property (@(posedge clk) disable iff (!rst_n) (lclk_o && $past(lclk_o)) |=> !lclk_o); // R6
    AST_FULL_BURST: assert property (@(posedge clk) disable iff (!rst_n) $rose(lclk_o) |-> ({x_o, y_o, z_o} == 3'b111 || {x_o, y_o, z_o} == 3'b000)); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err_o |=> err_o); // R7
endmodule

bind burst_lclk_fsm burst_lclk_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .x_o     (x_o),
    .y_o     (y_o),
    .z_o     (z_o),
    .lclk_o  (lclk_o),
    .p1_en_o (p1_en_o),
    .p2_en_o (p2_en_o),
    .err_o   (err_o)
);

// File: tb/burst_lclk_fsm_tb.sv
module burst_lclk_fsm_tb;
    localparam int SETTLE = 3;
    localparam int HOLD   = SETTLE + 12;
    localparam int NVEC   = 15;
    // {a,b,c, expected x,y,z, expected local clock firings}
    localparam logic [6:0] VEC [NVEC] = '{
        7'b000_000_0, 7'b100_000_0, 7'b110_001_0, 7'b111_111_1,
        7'b011_111_0, 7'b001_111_0, 7'b000_000_1, 7'b001_000_0,
        7'b101_000_0, 7'b111_111_1, 7'b000_000_1, 7'b010_000_0,
        7'b110_001_0, 7'b100_000_0, 7'b000_000_0
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic a = 1'b0, b = 1'b0, c = 1'b0;
    logic x, y, z, lclk, p1_en, p2_en, err;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    burst_lclk_fsm #(.SETTLE_CYC(SETTLE)) u_dut (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .c_i(c),
        .x_o(x), .y_o(y), .z_o(z), .lclk_o(lclk),
        .p1_en_o(p1_en), .p2_en_o(p2_en), .err_o(err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold_count(input int n, output int rises);
        logic prev;
        rises = 0;
        prev  = lclk;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (lclk && !prev) rises++;
            prev = lclk;
        end
    endtask

    initial begin
        #(20ns * 200000);
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int rises, cnt, hi;
        logic [2:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 xyz", int'({x, y, z}), 0);
        chk("R1 lclk/p2/err", int'({lclk, p2_en, err}), 0);
        chk("R1 p1_en", int'(p1_en), 1);
        rst_n = 1'b1;

        // Vector table: R2 (state 0), R3 (state 1), R4 (firing only on full bursts)
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            {a, b, c} = VEC[i][6:4];
            hold_count(HOLD, rises);
            chk($sformatf("R2/R3 vec%0d xyz", i), int'({x, y, z}), int'(VEC[i][3:1]));
            chk($sformatf("R4 vec%0d firings", i), rises, int'(VEC[i][0]));
            chk($sformatf("R7 vec%0d idle err", i), int'(err), 0);
        end

        // R5/R6: firing latency, width, phase enables and frozen outputs
        {a, b, c} = 3'b110;
        hold_count(HOLD, rises);
        @(negedge clk);
        c = 1'b1;
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!lclk && cnt < 50);
        chk("R5 edges to local clock", cnt, SETTLE + 2);
        chk("R4 xyz at firing", int'({x, y, z}), 7);
        held = {x, y, z};
        hi = 0;
        while (lclk && hi < 20) begin
            hi++;
            chk("R6 p2 open p1 closed", int'({p2_en, p1_en}), 2);
            chk("R6 outputs frozen", int'({x, y, z}), int'(held));
            @(negedge clk);
        end
        chk("R6 local clock width", hi, 2);
        chk("R6 p1 reopened", int'(p1_en), 1);

        // R7: change inside a running sequence
        {a, b, c} = 3'b000;
        hold_count(HOLD, rises);
        {a, b, c} = 3'b110;
        hold_count(HOLD, rises);
        c = 1'b1;
        @(negedge clk);
        @(negedge clk);
        a = 1'b0;
        @(negedge clk);
        chk("R7 error raised", int'(err), 1);
        chk("R7 outputs ignore glitch", int'({x, y, z}), 7);
        a = 1'b1;
        hold_count(HOLD, rises);
        chk("R7 burst still completes", int'({x, y, z}), 7);
        chk("R7 error sticky", int'(err), 1);

        // R1: reset clears the flag and state
        rst_n = 1'b0;
        {a, b, c} = 3'b000;
        repeat (2) @(negedge clk);
        chk("R1 err cleared", int'(err), 0);
        chk("R1 xyz cleared", int'({x, y, z}), 0);
        rst_n = 1'b1;
        {a, b, c} = 3'b111;
        hold_count(HOLD, rises);
        chk("R1 back in state 0 (fires on full burst)", rises, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule